// File: doc/BRIEF.md
# Raster Timing Generator with Frame, Line and Pixel Counters

This block produces the horizontal and vertical raster timing of a display pipe from a set of programmable totals, blank positions and sync positions. It runs on the pixel clock, one clock per pixel, and drives hsync, vsync, horizontal and vertical blank, and a combined blank. Alongside the raster it keeps three position counters: the current scanline, a pixel counter that measures position within the frame, and a 24-bit frame counter presented as a 16-bit upper field and an 8-bit lower field.

Three single-cycle strobes mark points of interest in the raster. The start-of-vblank strobe and the vsync strobe both fire at the start of horizontal sync on the line before the event, not at the start of a line. The frame-start strobe fires at the start of horizontal blank one to four lines later. A configuration latch pulse coincides with the start-of-vblank strobe: the timing inputs are shadow values that software may change at any time, and they only reach the active set on that pulse, so a frame in progress is never scanned with a half-applied configuration.

Positions are counted from zero: pixel 0 of line 0 is the first active pixel of a frame. A pixel is horizontally blanked when its position is at or past the horizontal blank start, and a line is vertically blanked when it is at or past the vertical blank start. The frame counter can be told to step at start of vblank or at the first active pixel.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel position runs 0 to htotal-1 and then returns to 0; hblank_o is high while the position is at or above the horizontal blank start, and hsync_o is high while it is at or above the hsync start and below the hsync end.
- R2: The scanline output advances by one when the pixel position leaves htotal-1 and returns to 0 after vtotal-1; vblank_o is high on lines at or above the vertical blank start, vsync_o on lines at or above the vsync start and below the vsync end, and blank_o is the OR of hblank_o and vblank_o.
- R3: vbl_stb_o is high for exactly one clock, at the pixel equal to the hsync start on the line one below the vertical blank start.
- R4: latch_o is high in the same clock as vbl_stb_o; the shadow timing inputs present at that clock are in force from the next clock, and shadow changes at any other time while running have no effect on the outputs.
- R5: vs_stb_o is high for exactly one clock, at the pixel equal to the hsync start on the line one below the vsync start.
- R6: fs_stb_o is high for one clock at the pixel equal to the horizontal blank start on line vblank start + extra, where extra is the 2-bit frame-start delay (0..3), taken modulo vtotal.
- R7: pixel_o is 0 at the first active pixel of a frame and rises by one per clock, so it equals vblank start × htotal at pixel 0 of the first blanked line.
- R8: With the frame counter mode at 0 the frame count is one higher from the clock after vbl_stb_o; with mode 1 it is one higher from the clock that shows pixel 0 of line 0 after a frame wrap (not on the first frame after enable).
- R9: The frame count is 24 bits wide and wraps modulo 2^24; frame_hi_o carries bits 23:8 and frame_lo_o bits 7:0.
- R10: While en is low all syncs, blanks and strobes are low, scanline and pixel are 0, the frame count holds, and the shadow set is copied into the active set every clock; one clock after en rises the outputs show pixel 0 of line 0.
- R11: After reset every output is 0, including the frame count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| sh_htotal | input | 12 | Shadow pixels per line |
| sh_hblank_start | input | 12 | Shadow first horizontally blanked pixel |
| sh_hsync_start | input | 12 | Shadow first hsync pixel |
| sh_hsync_end | input | 12 | Shadow first pixel after hsync |
| sh_vtotal | input | 12 | Shadow lines per frame |
| sh_vblank_start | input | 12 | Shadow first vertically blanked line |
| sh_vsync_start | input | 12 | Shadow first vsync line |
| sh_vsync_end | input | 12 | Shadow first line after vsync |
| sh_fs_delay | input | 2 | Shadow extra frame-start delay in lines |
| sh_fc_mode | input | 1 | Shadow frame counter mode: 0 at vblank, 1 at first active pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| blank_o | output | 1 | Combined blank |
| scanline_o | output | 12 | Current line |
| pixel_o | output | 24 | Pixel position within the frame |
| frame_hi_o | output | 16 | Frame count bits 23:8 |
| frame_lo_o | output | 8 | Frame count bits 7:0 |
| vbl_stb_o | output | 1 | Start-of-vblank strobe |
| fs_stb_o | output | 1 | Frame-start strobe |
| vs_stb_o | output | 1 | Start-of-vsync strobe |
| latch_o | output | 1 | Configuration latch pulse |

## Verification
A horizontal position that strays shows up within one line as a sync or blank edge on the wrong pixel, and within the same line as a misplaced strobe. A wrong line count or a configuration taken at the wrong moment moves the vblank, vsync and frame-start strobes to another line in the current or next frame, and shifts the pixel counter against the value expected at the first blanked line. Faults in the frame counter step or mode appear at the next vblank or frame wrap, at most one frame later, in the upper and lower count fields.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int H_W        = 12;
    localparam int V_W        = 12;
    localparam int PIX_W      = H_W + V_W;
    localparam int FRAME_W    = 24;
    localparam int FRAME_LO_W = 8;
    localparam int FRAME_HI_W = FRAME_W - FRAME_LO_W;
    localparam int FS_DLY_W   = 2;

    typedef enum logic {
        FC_AT_VBLANK = 1'b0,
        FC_AT_ACTIVE = 1'b1
    } fc_mode_e;

    typedef struct packed {
        logic [H_W-1:0] total;
        logic [H_W-1:0] blank_start;
        logic [H_W-1:0] sync_start;
        logic [H_W-1:0] sync_end;
    } hcfg_t;

    typedef struct packed {
        logic [V_W-1:0]      total;
        logic [V_W-1:0]      blank_start;
        logic [V_W-1:0]      sync_start;
        logic [V_W-1:0]      sync_end;
        logic [FS_DLY_W-1:0] fs_extra;
        fc_mode_e            fc_mode;
    } vcfg_t;

    // Line on which frame start lands: blank start plus the extra delay, wrapped.
    function automatic logic [V_W-1:0] fs_line(input logic [V_W-1:0]      vbs,
                                               input logic [FS_DLY_W-1:0] extra,
                                               input logic [V_W-1:0]      vtot);
        logic [V_W:0] sum;
        sum = {1'b0, vbs} + {{(V_W+1-FS_DLY_W){1'b0}}, extra};
        if (sum >= {1'b0, vtot})
            sum = sum - {1'b0, vtot};
        return sum[V_W-1:0];
    endfunction

    // True when the current line is the one just before the target line.
    function automatic logic line_before(input logic [V_W-1:0] cur,
                                         input logic [V_W-1:0] target);
        return ({1'b0, cur} + (V_W+1)'(1)) == {1'b0, target};
    endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
    import raster_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           adv,
    input  hcfg_t          cfg,
    output logic [H_W-1:0] h_o,
    output logic           eol_o,
    output logic           at_hbs_o,
    output logic           at_hss_o,
    output logic           in_hblank_o,
    output logic           in_hsync_o
);

    logic [H_W-1:0] h_q;

    assign eol_o       = (h_q == cfg.total - H_W'(1));
    assign at_hbs_o    = (h_q == cfg.blank_start);
    assign at_hss_o    = (h_q == cfg.sync_start);
    assign in_hblank_o = (h_q >= cfg.blank_start);
    assign in_hsync_o  = (h_q >= cfg.sync_start) && (h_q < cfg.sync_end);
    assign h_o         = h_q;

    always_ff @(posedge clk) begin
        if (clr)
            h_q <= '0;
        else if (adv)
            h_q <= eol_o ? '0 : h_q + H_W'(1);
    end

    // R1: horizontal position only steps by one or returns to zero
    p_h_step_r1: assert property (@(posedge clk) disable iff (rst)
        (h_q != $past(h_q)) |-> (h_q == '0 || h_q == $past(h_q) + H_W'(1)));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
    import raster_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           adv,
    input  logic           eol,
    input  vcfg_t          cfg,
    output logic [V_W-1:0] v_o,
    output logic           eof_o,
    output logic           in_vblank_o,
    output logic           in_vsync_o,
    output logic           pre_vbl_o,
    output logic           pre_vs_o,
    output logic           fs_hit_o
);

    logic [V_W-1:0] v_q;
    logic [V_W-1:0] fs_target;

    assign fs_target   = fs_line(cfg.blank_start, cfg.fs_extra, cfg.total);
    assign eof_o       = (v_q == cfg.total - V_W'(1));
    assign in_vblank_o = (v_q >= cfg.blank_start);
    assign in_vsync_o  = (v_q >= cfg.sync_start) && (v_q < cfg.sync_end);
    assign pre_vbl_o   = line_before(v_q, cfg.blank_start);
    assign pre_vs_o    = line_before(v_q, cfg.sync_start);
    assign fs_hit_o    = (v_q == fs_target);
    assign v_o         = v_q;

    always_ff @(posedge clk) begin
        if (clr)
            v_q <= '0;
        else if (adv && eol)
            v_q <= eof_o ? '0 : v_q + V_W'(1);
    end

    // R2: scanline only steps by one or returns to zero
    p_line_step_r2: assert property (@(posedge clk) disable iff (rst)
        (v_q != $past(v_q)) |-> (v_q == '0 || v_q == $past(v_q) + V_W'(1)));

    // R2: the line never moves unless the previous clock ended a line or cleared
    p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!clr) && !$past(eol)) |-> $stable(v_q));

endmodule

// File: rtl/raster_events.sv
module raster_events
    import raster_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               adv,
    input  logic               run,
    input  logic               eol,
    input  logic               eof,
    input  logic               at_hss,
    input  logic               at_hbs,
    input  logic               pre_vbl,
    input  logic               pre_vs,
    input  logic               fs_hit,
    input  fc_mode_e           fc_mode,
    output logic               vbl_stb_o,
    output logic               vs_stb_o,
    output logic               fs_stb_o,
    output logic [PIX_W-1:0]   pix_o,
    output logic [FRAME_W-1:0] frame_o
);

    logic               frame_inc;
    logic               frame_wrap;
    logic [PIX_W-1:0]   pix_q;
    logic [FRAME_W-1:0] frame_q;

    // Events sit on the hsync start of the line ahead; frame start on hblank start.
    assign vbl_stb_o  = run && at_hss && pre_vbl;
    assign vs_stb_o   = run && at_hss && pre_vs;
    assign fs_stb_o   = run && at_hbs && fs_hit;
    assign frame_wrap = eol && eof;
    assign frame_inc  = (fc_mode == FC_AT_ACTIVE) ? frame_wrap : vbl_stb_o;

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= '0;
        else if (adv && frame_inc)
            frame_q <= frame_q + FRAME_W'(1);
    end

    always_ff @(posedge clk) begin
        if (clr)
            pix_q <= '0;
        else if (adv)
            pix_q <= frame_wrap ? '0 : pix_q + PIX_W'(1);
    end

    assign pix_o   = pix_q;
    assign frame_o = frame_q;

    // R3: start-of-vblank strobe lasts one clock
    p_vbl_single_r3: assert property (@(posedge clk) disable iff (rst)
        vbl_stb_o |=> !vbl_stb_o);

    // R5: vsync strobe lasts one clock
    p_vs_single_r5: assert property (@(posedge clk) disable iff (rst)
        vs_stb_o |=> !vs_stb_o);

    // R6: frame-start strobe lasts one clock
    p_fs_single_r6: assert property (@(posedge clk) disable iff (rst)
        fs_stb_o |=> !fs_stb_o);

    // R7: pixel position restarts at zero after the last pixel of a frame
    p_pix_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && frame_wrap) |=> (pix_q == '0));

    // R8: frame count never jumps by more than one
    p_frame_step_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_q != $past(frame_q)) |-> (frame_q == $past(frame_q) + FRAME_W'(1)));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [H_W-1:0]        sh_htotal,
    input  logic [H_W-1:0]        sh_hblank_start,
    input  logic [H_W-1:0]        sh_hsync_start,
    input  logic [H_W-1:0]        sh_hsync_end,
    input  logic [V_W-1:0]        sh_vtotal,
    input  logic [V_W-1:0]        sh_vblank_start,
    input  logic [V_W-1:0]        sh_vsync_start,
    input  logic [V_W-1:0]        sh_vsync_end,
    input  logic [FS_DLY_W-1:0]   sh_fs_delay,
    input  logic                  sh_fc_mode,
    output logic                  hsync_o,
    output logic                  vsync_o,
    output logic                  hblank_o,
    output logic                  vblank_o,
    output logic                  blank_o,
    output logic [V_W-1:0]        scanline_o,
    output logic [PIX_W-1:0]      pixel_o,
    output logic [FRAME_HI_W-1:0] frame_hi_o,
    output logic [FRAME_LO_W-1:0] frame_lo_o,
    output logic                  vbl_stb_o,
    output logic                  fs_stb_o,
    output logic                  vs_stb_o,
    output logic                  latch_o
);

    hcfg_t sh_h, act_h;
    vcfg_t sh_v, act_v;

    logic run_q;
    logic clr, adv;
    logic [H_W-1:0] h_pos;
    logic eol, eof;
    logic at_hbs, at_hss, in_hblank, in_hsync;
    logic in_vblank, in_vsync, pre_vbl, pre_vs, fs_hit;
    logic vbl_stb, vs_stb, fs_stb;
    logic [FRAME_W-1:0] frame_cnt;

    assign sh_h = '{total: sh_htotal, blank_start: sh_hblank_start,
                    sync_start: sh_hsync_start, sync_end: sh_hsync_end};
    assign sh_v = '{total: sh_vtotal, blank_start: sh_vblank_start,
                    sync_start: sh_vsync_start, sync_end: sh_vsync_end,
                    fs_extra: sh_fs_delay, fc_mode: fc_mode_e'(sh_fc_mode)};

    assign clr = rst || !en;
    assign adv = run_q && en && !rst;

    // The first enabled clock parks on pixel 0 of line 0; counting starts after it.
    always_ff @(posedge clk) begin
        if (clr)
            run_q <= 1'b0;
        else
            run_q <= 1'b1;
    end

    // Active timing set: follows the shadow while idle, else only on the latch pulse.
    always_ff @(posedge clk) begin
        if (clr || vbl_stb) begin
            act_h <= sh_h;
            act_v <= sh_v;
        end
    end

    raster_hcount u_hcount (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .adv         (adv),
        .cfg         (act_h),
        .h_o         (h_pos),
        .eol_o       (eol),
        .at_hbs_o    (at_hbs),
        .at_hss_o    (at_hss),
        .in_hblank_o (in_hblank),
        .in_hsync_o  (in_hsync)
    );

    raster_vcount u_vcount (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .adv         (adv),
        .eol         (eol),
        .cfg         (act_v),
        .v_o         (scanline_o),
        .eof_o       (eof),
        .in_vblank_o (in_vblank),
        .in_vsync_o  (in_vsync),
        .pre_vbl_o   (pre_vbl),
        .pre_vs_o    (pre_vs),
        .fs_hit_o    (fs_hit)
    );

    raster_events u_events (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .adv       (adv),
        .run       (run_q),
        .eol       (eol),
        .eof       (eof),
        .at_hss    (at_hss),
        .at_hbs    (at_hbs),
        .pre_vbl   (pre_vbl),
        .pre_vs    (pre_vs),
        .fs_hit    (fs_hit),
        .fc_mode   (act_v.fc_mode),
        .vbl_stb_o (vbl_stb),
        .vs_stb_o  (vs_stb),
        .fs_stb_o  (fs_stb),
        .pix_o     (pixel_o),
        .frame_o   (frame_cnt)
    );

    assign hsync_o    = run_q && in_hsync;
    assign hblank_o   = run_q && in_hblank;
    assign vsync_o    = run_q && in_vsync;
    assign vblank_o   = run_q && in_vblank;
    assign blank_o    = hblank_o || vblank_o;
    assign vbl_stb_o  = vbl_stb;
    assign vs_stb_o   = vs_stb;
    assign fs_stb_o   = fs_stb;
    assign latch_o    = vbl_stb;
    assign frame_hi_o = frame_cnt[FRAME_W-1:FRAME_LO_W];
    assign frame_lo_o = frame_cnt[FRAME_LO_W-1:0];

    // R4: the latch pulse brings the shadow set into force on the next clock
    p_latch_copy_r4: assert property (@(posedge clk) disable iff (rst)
        latch_o |=> (act_h == $past(sh_h)) && (act_v == $past(sh_v)));

    // R4: while running, the active set only moves after a latch pulse
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q && !$past(latch_o)) |-> ($stable(act_h) && $stable(act_v)));

    // R10: nothing toggles in the parked clock before counting starts
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (!hsync_o && !vsync_o && !blank_o && h_pos == '0 && scanline_o == '0));

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    import raster_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, en = 1'b0;
    logic [H_W-1:0] sh_ht = 0, sh_hbs = 0, sh_hss = 0, sh_hse = 0;
    logic [V_W-1:0] sh_vt = 0, sh_vbs = 0, sh_vss = 0, sh_vse = 0;
    logic [1:0] sh_fsd = 0;
    logic sh_fc = 0;

    logic hsync, vsync, hblank, vblank, blank, vbl_stb, fs_stb, vs_stb, latch;
    logic [V_W-1:0] scanline;
    logic [PIX_W-1:0] pixel;
    logic [FRAME_HI_W-1:0] fhi;
    logic [FRAME_LO_W-1:0] flo;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst(rst), .en(en),
        .sh_htotal(sh_ht), .sh_hblank_start(sh_hbs), .sh_hsync_start(sh_hss),
        .sh_hsync_end(sh_hse), .sh_vtotal(sh_vt), .sh_vblank_start(sh_vbs),
        .sh_vsync_start(sh_vss), .sh_vsync_end(sh_vse), .sh_fs_delay(sh_fsd),
        .sh_fc_mode(sh_fc),
        .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank),
        .blank_o(blank), .scanline_o(scanline), .pixel_o(pixel),
        .frame_hi_o(fhi), .frame_lo_o(flo), .vbl_stb_o(vbl_stb), .fs_stb_o(fs_stb),
        .vs_stb_o(vs_stb), .latch_o(latch)
    );

    // Values to apply at the next negative edge
    bit n_rst = 1, n_en = 0;
    int n_ht, n_hbs, n_hss, n_hse, n_vt, n_vbs, n_vss, n_vse, n_fsd, n_fc;

    // Reference model state
    int mh, mv, a_ht, a_hbs, a_hss, a_hse, a_vt, a_vbs, a_vss, a_vse, a_fsd, a_fc;
    longint mpix, mframe;
    bit mrun, model_ok = 0;

    int vecs = 0, errs = 0, cycles = 0;

    task automatic chk(input string req, input string nm, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int ht, hbs, hss, hse, vbs, fsd, fc);
        n_ht = ht; n_hbs = hbs; n_hss = hss; n_hse = hse;
        n_vbs = vbs; n_vt = vbs + 3; n_vss = vbs + 1; n_vse = vbs + 2;
        n_fsd = fsd; n_fc = fc;
    endtask

    task automatic load_active();
        a_ht = n_ht; a_hbs = n_hbs; a_hss = n_hss; a_hse = n_hse;
        a_vt = n_vt; a_vbs = n_vbs; a_vss = n_vss; a_vse = n_vse;
        a_fsd = n_fsd; a_fc = n_fc;
    endtask

    task automatic compare();
        int fsl;
        bit e_hb, e_hs, e_vb, e_vs, e_vbl, e_vst, e_fs;
        string t1, t2, t3, t5, t6;
        fsl = a_vbs + a_fsd;
        if (fsl >= a_vt) fsl -= a_vt;
        e_hb  = mrun && mh >= a_hbs;
        e_hs  = mrun && mh >= a_hss && mh < a_hse;
        e_vb  = mrun && mv >= a_vbs;
        e_vs  = mrun && mv >= a_vss && mv < a_vse;
        e_vbl = mrun && mh == a_hss && mv + 1 == a_vbs;
        e_vst = mrun && mh == a_hss && mv + 1 == a_vss;
        e_fs  = mrun && mh == a_hbs && mv == fsl;
        t1 = mrun ? "R1" : "R10";  t2 = mrun ? "R2" : "R10";
        t3 = mrun ? "R3" : "R10";  t5 = mrun ? "R5" : "R10";
        t6 = mrun ? "R6" : "R10";
        chk(t1, "hblank", hblank, e_hb);
        chk(t1, "hsync", hsync, e_hs);
        chk(t2, "vblank", vblank, e_vb);
        chk(t2, "vsync", vsync, e_vs);
        chk(t2, "blank", blank, e_hb | e_vb);
        chk(t2, "scanline", scanline, mv);
        chk(t3, "vbl_stb", vbl_stb, e_vbl);
        chk("R4", "latch", latch, e_vbl);
        chk(t5, "vs_stb", vs_stb, e_vst);
        chk(t6, "fs_stb", fs_stb, e_fs);
        chk(mrun ? "R7" : "R10", "pixel", pixel, mpix);
        chk("R8", "frame_lo", flo, mframe & 8'hFF);
        chk("R9", "frame_hi", fhi, (mframe >> 8) & 16'hFFFF);
    endtask

    task automatic cyc();
        bit eol, eof, vst, inc;
        @(negedge clk);
        if (model_ok) compare();
        rst = n_rst; en = n_en;
        sh_ht = H_W'(n_ht); sh_hbs = H_W'(n_hbs); sh_hss = H_W'(n_hss); sh_hse = H_W'(n_hse);
        sh_vt = V_W'(n_vt); sh_vbs = V_W'(n_vbs); sh_vss = V_W'(n_vss); sh_vse = V_W'(n_vse);
        sh_fsd = 2'(n_fsd); sh_fc = 1'(n_fc);
        if (n_rst || !n_en) begin
            if (n_rst) mframe = 0;
            mh = 0; mv = 0; mpix = 0; mrun = 0;
            load_active();
        end else if (!mrun) begin
            mrun = 1;
        end else begin
            eol = (mh == a_ht - 1);
            eof = (mv == a_vt - 1);
            vst = (mh == a_hss && mv + 1 == a_vbs);
            inc = a_fc ? (eol && eof) : vst;
            if (inc) mframe = (mframe + 1) & 64'hFFFFFF;
            mpix = (eol && eof) ? 0 : mpix + 1;
            if (eol) begin mh = 0; mv = eof ? 0 : mv + 1; end
            else mh = mh + 1;
            if (vst) load_active();
        end
        model_ok = 1;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++;
            $display("FAIL R10 watchdog actual=%0d expected=150000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd5171));
        // Directed: 10 pixels x 7 lines, vblank from line 4
        set_cfg(10, 6, 7, 9, 4, 0, 0);
        n_rst = 1; n_en = 0;
        run_cycles(3);
        // R11: reset state at the ports
        chk("R11", "pixel", pixel, 0);
        chk("R11", "frame", {fhi, flo}, 0);
        chk("R11", "syncs", {hsync, vsync, blank, vbl_stb, fs_stb, vs_stb, latch}, 0);
        n_rst = 0; n_en = 1;
        run_cycles(40);
        // R7: pixel 0 of line 4 holds 4*10
        while (!(scanline == 4 && hblank == 0 && blank == 1)) cyc();
        chk("R7", "pixel_at_vbs", pixel, 40);
        run_cycles(150);
        // R4: shadow change mid-frame, new set taken only at the latch pulse
        set_cfg(12, 8, 9, 11, 5, 3, 1);
        run_cycles(320);
        // R10: disable for a while, frame count must hold
        n_en = 0;
        run_cycles(6);
        n_en = 1;
        run_cycles(260);
        // Constrained random configurations, started from idle
        for (int k = 0; k < 24; k++) begin
            int ht, hbs, hss, hse, vbs;
            ht  = 6 + int'($urandom % 20);
            hbs = 1 + int'($urandom % (ht - 2));
            hss = hbs + int'($urandom % (ht - 1 - hbs));
            hse = hss + 1 + int'($urandom % (ht - hss));
            vbs = 3 + int'($urandom % 6);
            n_en = 0;
            set_cfg(ht, hbs, hss, hse, vbs, int'($urandom % 4), int'($urandom % 2));
            run_cycles(2);
            n_en = 1;
            run_cycles(3 * ht * (vbs + 3) + 7);
        end
        // R11: reset while running clears the frame count too
        n_rst = 1;
        run_cycles(2);
        n_rst = 0;
        run_cycles(200);
        finish_run();
    end

endmodule